// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Watermark Flag

This block is a first-in first-out buffer of 256 words of 18 bits that sits between two clock domains. A producer presents a word and pulses a load strobe on its own clock, and a consumer pulses an unload strobe on a second clock and receives the oldest stored word on a registered output. The two clocks may be unrelated, or they may be one and the same. Write and read positions cross between the domains as Gray-coded pointers through two-stage synchronizers.

Four status outputs report the fill level. There is an active-low full output, an active-low empty output and a half-full output. The fourth is a single watermark output that is raised both when the buffer is nearly drained and when it is nearly filled. The two watermark distances are loaded from the low byte of the data bus. This happens on the first one or two load strobes after reset, while the active-low program input is held low, and those strobes store no data. Reset is active high and is sampled on the edges of each clock. It must stay asserted across at least three edges of both clocks.

Top module: `strobe_fifo`

## Requirements
- R1: Words are returned in the order they were loaded, all 18 bits intact, and up to 256 words can be held at once.
- R2: A load strobe while the buffer holds 256 words stores nothing and leaves every held word unchanged.
- R3: An unload strobe while the buffer is empty changes neither the output data nor the buffer state.
- R4: `full_n` is 0 when 256 words are held and 1 otherwise, once recent reads have crossed into the load domain.
- R5: `empty_n` is 0 when no word is held and 1 otherwise, once recent writes have crossed into the unload domain.
- R6: `half_full` is 1 exactly when at least 128 words are held.
- R7: After reset with `prog_n` low, the first load strobe takes the low-watermark distance L from `din[7:0]` and the second takes the high-watermark distance H from `din[7:0]`; neither strobe stores a word.
- R8: `wmark` is 1 when the held count is at most L or at least 256 − H, and 0 for counts from L+1 to 255 − H.
- R9: If `prog_n` goes high after exactly one programming strobe, H takes the value of L.
- R10: With no programming after reset, L and H are both 32.
- R11: `dout` is registered and changes only on an unload-clock edge that removes a word; reset clears it to 0.
- R12: While `oe_n` is 1, `dout` reads as all zeros, and the held value returns when `oe_n` goes back to 0.
- R13: Operation is correct both with two unrelated clocks and with one clock driving both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ld_clk | input | 1 | Load-side clock |
| ul_clk | input | 1 | Unload-side clock |
| rst | input | 1 | Active-high reset, sampled by both clocks |
| prog_n | input | 1 | Active-low enable for watermark programming after reset |
| ld_stb | input | 1 | Load strobe, sampled on rising `ld_clk` |
| ul_stb | input | 1 | Unload strobe, sampled on rising `ul_clk` |
| oe_n | input | 1 | Active-low output enable; when high, `dout` is forced to zero |
| din | input | 18 | Data to load; the low byte carries watermark distances when programming |
| dout | output | 18 | Oldest word removed by the last unload |
| full_n | output | 1 | Low when 256 words are held |
| empty_n | output | 1 | Low when no word is held |
| half_full | output | 1 | High when 128 or more words are held |
| wmark | output | 1 | High when the held count is at or below L, or at or above 256 − H |

## Verification
The assertions assume that reset is held over several edges of both clocks. They also assume that each strobe is sampled as a level on its own clock edge, so that every Gray pointer changes by at most one bit per edge of its own domain. The stimulus changes every input on falling edges and holds reset for five edges of each clock. It compares flags only after both synchronizers have had time to settle.

While the clocks are unrelated, the bench keeps the fill level well away from both 0 and 256. A flag that deasserts late can then never make the model and the design disagree on whether a strobe was accepted. Full fill-and-drain sweeps are run under three watermark settings, so that every fill level is visited for each of them.

// File: rtl/strobe_fifo_pkg.sv
`timescale 1ns/1ps
package strobe_fifo_pkg;

    // width of a watermark distance, taken from the low data bits
    localparam int OFS_W = 8;

    typedef logic [OFS_W-1:0] ofs_t;

    // progress of the watermark programming sequence after reset
    typedef enum logic [1:0] {
        PRG_LOW_MARK,
        PRG_HIGH_MARK,
        PRG_DONE
    } prg_state_e;

    typedef struct packed {
        ofs_t low_mark;
        ofs_t high_mark;
    } marks_t;

    typedef struct packed {
        logic full;
        logic half;
        logic watermark;
    } ld_flags_t;

endpackage

// File: rtl/fifo_gray_sync.sv
`timescale 1ns/1ps
module fifo_gray_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    // Gray to binary: each bit is the XOR of all Gray bits at or above it
    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            acc        = acc ^ stage2[i];
            bin_out[i] = acc;
        end
    end

endmodule

// File: rtl/fifo_ram.sv
`timescale 1ns/1ps
module fifo_ram #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 8
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/fifo_load_ctl.sv
`timescale 1ns/1ps
module fifo_load_ctl
    import strobe_fifo_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DEF_MARK = 32,
    localparam int PTR_W   = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic              prog_n,
    input  ofs_t              mark_in,
    input  logic [PTR_W-1:0]  rd_bin_sync,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [PTR_W-1:0]  wr_gray,
    output ld_flags_t         flags
);

    localparam int   DEPTH   = 1 << ADDR_W;
    localparam ofs_t DEF_OFS = ofs_t'(DEF_MARK);

    prg_state_e       state;
    marks_t           marks;
    logic [PTR_W-1:0] wr_bin;
    logic [PTR_W-1:0] wr_bin_nxt;
    logic [PTR_W-1:0] occ;
    logic [PTR_W-1:0] hi_level;
    logic             prog_cycle;

    function automatic logic [PTR_W-1:0] to_gray(input logic [PTR_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    assign prog_cycle = (state != PRG_DONE) && !prog_n;
    assign wr_bin_nxt = wr_bin + PTR_W'(1);
    assign wr_addr    = wr_bin[ADDR_W-1:0];

    // occupancy as seen from the load domain (reads may appear late)
    assign occ      = wr_bin - rd_bin_sync;
    assign hi_level = PTR_W'(DEPTH) - PTR_W'(marks.high_mark);

    assign flags.full      = (occ == PTR_W'(DEPTH));
    assign flags.half      = (occ >= PTR_W'(DEPTH / 2));
    assign flags.watermark = (occ <= PTR_W'(marks.low_mark)) || (occ >= hi_level);

    assign wr_en = stb && !prog_cycle && !flags.full;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_bin  <= '0;
            wr_gray <= '0;
        end else if (wr_en) begin
            wr_bin  <= wr_bin_nxt;
            wr_gray <= to_gray(wr_bin_nxt);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state           <= PRG_LOW_MARK;
            marks.low_mark  <= DEF_OFS;
            marks.high_mark <= DEF_OFS;
        end else begin
            unique case (state)
                PRG_LOW_MARK: begin
                    if (!prog_n && stb) begin
                        marks.low_mark <= mark_in;
                        state          <= PRG_HIGH_MARK;
                    end else if (prog_n) begin
                        state <= PRG_DONE;
                    end
                end
                PRG_HIGH_MARK: begin
                    if (!prog_n && stb) begin
                        marks.high_mark <= mark_in;
                        state           <= PRG_DONE;
                    end else if (prog_n) begin
                        marks.high_mark <= marks.low_mark;
                        state           <= PRG_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    // R4: the load domain never sees more than DEPTH words held
    p_occ_bound_r4: assert property (@(posedge clk) disable iff (rst)
        occ <= PTR_W'(DEPTH));

    // R2: a strobe while full does not advance the write pointer
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        (flags.full && stb) |=> $stable(wr_bin));

    // R7: programming strobes store no word
    p_prog_nowrite_r7: assert property (@(posedge clk) disable iff (rst)
        prog_cycle |=> $stable(wr_bin));

    // R6 / R8: a full buffer is also past half and inside the high watermark
    p_full_flags_r6: assert property (@(posedge clk) disable iff (rst)
        flags.full |-> (flags.half && flags.watermark));

    // R13: the pointer sent across domains moves by at most one Gray bit
    p_gray_step_r13: assert property (@(posedge clk) disable iff (rst)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

endmodule

// File: rtl/fifo_unload_ctl.sv
`timescale 1ns/1ps
module fifo_unload_ctl #(
    parameter int ADDR_W  = 8,
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic [PTR_W-1:0]  wr_bin_sync,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [PTR_W-1:0]  rd_gray,
    output logic              empty
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [PTR_W-1:0] rd_bin;
    logic [PTR_W-1:0] rd_bin_nxt;

    function automatic logic [PTR_W-1:0] to_gray(input logic [PTR_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    assign rd_bin_nxt = rd_bin + PTR_W'(1);
    assign rd_addr    = rd_bin[ADDR_W-1:0];
    assign empty      = (rd_bin == wr_bin_sync);
    assign rd_en      = stb && !empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_bin  <= '0;
            rd_gray <= '0;
        end else if (rd_en) begin
            rd_bin  <= rd_bin_nxt;
            rd_gray <= to_gray(rd_bin_nxt);
        end
    end

    // R3: a strobe while empty leaves the read pointer alone
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
        (empty && stb) |=> $stable(rd_bin));

    // R5: the unload domain never reads past the words it knows of
    p_fill_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_bin_sync - rd_bin) <= PTR_W'(DEPTH));

    // R13: the read pointer moves by at most one Gray bit per edge
    p_gray_step_r13: assert property (@(posedge clk) disable iff (rst)
        $countones(rd_gray ^ $past(rd_gray)) <= 1);

endmodule

// File: rtl/strobe_fifo.sv
`timescale 1ns/1ps
module strobe_fifo
    import strobe_fifo_pkg::*;
#(
    parameter int DATA_W   = 18,
    parameter int ADDR_W   = 8,
    parameter int DEF_MARK = 32
) (
    input  logic              ld_clk,
    input  logic              ul_clk,
    input  logic              rst,
    input  logic              prog_n,
    input  logic              ld_stb,
    input  logic              ul_stb,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              full_n,
    output logic              empty_n,
    output logic              half_full,
    output logic              wmark
);

    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0]  wr_gray;
    logic [PTR_W-1:0]  rd_gray;
    logic [PTR_W-1:0]  rd_bin_ld;
    logic [PTR_W-1:0]  wr_bin_ul;
    logic              wr_en;
    logic              rd_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic              empty;
    ld_flags_t         ldf;
    logic [DATA_W-1:0] rd_q;

    fifo_load_ctl #(.ADDR_W(ADDR_W), .DEF_MARK(DEF_MARK)) u_load (
        .clk         (ld_clk),
        .rst         (rst),
        .stb         (ld_stb),
        .prog_n      (prog_n),
        .mark_in     (din[OFS_W-1:0]),
        .rd_bin_sync (rd_bin_ld),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_gray     (wr_gray),
        .flags       (ldf)
    );

    fifo_unload_ctl #(.ADDR_W(ADDR_W)) u_unload (
        .clk         (ul_clk),
        .rst         (rst),
        .stb         (ul_stb),
        .wr_bin_sync (wr_bin_ul),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .rd_gray     (rd_gray),
        .empty       (empty)
    );

    fifo_gray_sync #(.W(PTR_W)) u_rd_to_ld (
        .clk     (ld_clk),
        .rst     (rst),
        .gray_in (rd_gray),
        .bin_out (rd_bin_ld)
    );

    fifo_gray_sync #(.W(PTR_W)) u_wr_to_ul (
        .clk     (ul_clk),
        .rst     (rst),
        .gray_in (wr_gray),
        .bin_out (wr_bin_ul)
    );

    fifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wr_clk  (ld_clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (din),
        .rd_clk  (ul_clk),
        .rd_rst  (rst),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_q)
    );

    assign dout      = oe_n ? '0 : rd_q;
    assign full_n    = !ldf.full;
    assign empty_n   = !empty;
    assign half_full = ldf.half;
    assign wmark     = ldf.watermark;

    // R11: the output register holds unless a word is actually removed
    p_dout_hold_r11: assert property (@(posedge ul_clk) disable iff (rst)
        !rd_en |=> $stable(rd_q));

endmodule

// File: tb/strobe_fifo_bench.sv
`timescale 1ns/1ps
module strobe_fifo_bench;

    localparam int DW    = 18;
    localparam int DEPTH = 256;

    logic          ld_clk  = 1'b0;
    logic          alt_clk = 1'b0;
    logic          use_alt = 1'b0;
    logic          ul_clk;
    logic          rst     = 1'b1;
    logic          prog_n  = 1'b1;
    logic          ld_stb  = 1'b0;
    logic          ul_stb  = 1'b0;
    logic          oe_n    = 1'b0;
    logic [DW-1:0] din     = '0;
    logic [DW-1:0] dout;
    logic          full_n;
    logic          empty_n;
    logic          half_full;
    logic          wmark;

    always #10 ld_clk = ~ld_clk;
    always #18.5 alt_clk = ~alt_clk;
    assign ul_clk = use_alt ? alt_clk : ld_clk;

    strobe_fifo u_strobe_fifo (
        .ld_clk    (ld_clk),
        .ul_clk    (ul_clk),
        .rst       (rst),
        .prog_n    (prog_n),
        .ld_stb    (ld_stb),
        .ul_stb    (ul_stb),
        .oe_n      (oe_n),
        .din       (din),
        .dout      (dout),
        .full_n    (full_n),
        .empty_n   (empty_n),
        .half_full (half_full),
        .wmark     (wmark)
    );

    int            checks   = 0;
    int            failures = 0;
    bit            finished = 1'b0;
    logic [DW-1:0] model_q[$];
    int            exp_low  = 32;
    int            exp_high = 32;
    logic [DW-1:0] last_out = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pattern(input int i);
        return DW'((i * 2731) ^ 32'h2A5C3);
    endfunction

    task automatic settle();
        repeat (4) @(negedge ld_clk);
        repeat (4) @(negedge ul_clk);
    endtask

    task automatic do_reset(input logic prog_level);
        rst    = 1'b1;
        prog_n = prog_level;
        ld_stb = 1'b0;
        ul_stb = 1'b0;
        repeat (5) @(negedge ld_clk);
        repeat (5) @(negedge ul_clk);
        rst = 1'b0;
        model_q.delete();
        exp_low  = 32;
        exp_high = 32;
        last_out = '0;
        @(negedge ld_clk);
    endtask

    // one load strobe; the model stores it only when it would be accepted
    task automatic do_load(input logic [DW-1:0] d, input bit counts);
        @(negedge ld_clk);
        din    = d;
        ld_stb = 1'b1;
        @(negedge ld_clk);
        ld_stb = 1'b0;
        if (counts && model_q.size() < DEPTH) model_q.push_back(d);
    endtask

    task automatic do_unload(input string req);
        @(negedge ul_clk);
        ul_stb = 1'b1;
        @(negedge ul_clk);
        ul_stb = 1'b0;
        if (model_q.size() > 0) last_out = model_q.pop_front();
        chk(req, dout, last_out);
    endtask

    task automatic check_flags(input string ctx);
        int occ;
        logic exp_w;
        occ   = model_q.size();
        exp_w = (occ <= exp_low) || (occ >= DEPTH - exp_high);
        chk({ctx, " R4 full_n"}, full_n, occ != DEPTH);
        chk({ctx, " R5 empty_n"}, empty_n, occ != 0);
        chk({ctx, " R6 half_full"}, half_full, occ >= DEPTH / 2);
        chk({ctx, " R8 wmark"}, wmark, exp_w);
    endtask

    // walk every fill level up to 256 and back down to 0
    task automatic fill_drain(input string ctx, input int seed);
        for (int i = 1; i <= DEPTH; i++) begin
            do_load(pattern(i + seed), 1'b1);
            settle();
            check_flags(ctx);
            chk({ctx, " R11 dout held"}, dout, last_out);
        end
        // R2: strobe while full is dropped
        do_load(18'h3FFFF, 1'b1);
        settle();
        check_flags({ctx, " R2"});
        for (int i = 1; i <= DEPTH; i++) begin
            do_unload({ctx, " R1 R2 order"});
            settle();
            check_flags(ctx);
        end
        // R3: strobe while empty changes nothing
        do_unload({ctx, " R3 dout"});
        settle();
        check_flags({ctx, " R3"});
    endtask

    initial begin
        repeat (190000) @(posedge ld_clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // reset state, default watermark distances (R10), one shared clock (R13)
        do_reset(1'b1);
        settle();
        check_flags("R10 reset");
        chk("R11 reset dout", dout, '0);
        fill_drain("R10", 0);

        // R12: output enable forces zero and then releases the held word
        do_load(18'h2B3C4, 1'b1);
        settle();
        do_unload("R1 single");
        oe_n = 1'b1;
        #1;
        chk("R12 oe_n high", dout, '0);
        oe_n = 1'b0;
        #1;
        chk("R12 oe_n low", dout, 18'h2B3C4);

        // R7: two programming strobes, L=5 H=10, upper bits ignored
        do_reset(1'b0);
        do_load(18'h3FF05, 1'b0);
        do_load(18'h1550A, 1'b0);
        prog_n = 1'b1;
        exp_low  = 5;
        exp_high = 10;
        settle();
        chk("R7 no word stored", empty_n, 1'b0);
        fill_drain("R7", 77);

        // R9: a single programming strobe, L=H=20
        do_reset(1'b0);
        do_load(18'h00014, 1'b0);
        @(negedge ld_clk);
        prog_n = 1'b1;
        exp_low  = 20;
        exp_high = 20;
        settle();
        chk("R9 no word stored", empty_n, 1'b0);
        fill_drain("R9", 311);

        // R13: unrelated clocks, fill level held well inside the buffer
        use_alt = 1'b1;
        do_reset(1'b1);
        for (int i = 0; i < 40; i++) do_load(pattern(i + 900), 1'b1);
        settle();
        check_flags("R13 async");
        for (int i = 0; i < 60; i++) begin
            do_unload("R13 R1 async order");
            do_load(pattern(i + 1000), 1'b1);
        end
        settle();
        check_flags("R13 async");
        while (model_q.size() > 0) do_unload("R13 R1 async drain");
        settle();
        check_flags("R13 async end");
        do_unload("R13 R3 async empty");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule